// File: doc/BRIEF.md
# Shared-Serial Debug Loader

This block sits between a soft processor and one serial port and lets a host put a fresh program into memory. Every incoming byte goes straight to the processor's receiver and also to a frame parser. Outgoing bytes pass through a two-way selector. The selector belongs to the debug side only. After reset the processor is held stalled and the selector gives the transmit line to the processor.

The host sends framed commands. A frame is made of these bytes, in order:

- sync bytes 0x5A then 0xA5;
- an opcode byte;
- a 32-bit address, least significant byte first;
- a word-count byte;
- the payload, if there is one;
- a checksum byte.

The checksum is the XOR of every byte after the sync pair. A frame that checks out moves the transmit line to the debug side. It is then carried out and answered. The debug side writes and reads memory through its own word port. That port is used only while the processor is held. A release command starts the processor at a chosen address and gives the line back.

The block is written as a byte-stream model. Bit-level serial framing and the processor core are outside it.

Top module: `dbg_loader_ctrl`

## Requirements
- R1: After reset, `cpu_hold` is 1, `tx_owner_dbg` is 0, `cpu_start_pc` equals RESET_PC and neither memory strobe is active.
- R2: `rx_valid`/`rx_data` appear unchanged on `cpu_rx_valid`/`cpu_rx_data` in the same cycle. While `tx_owner_dbg` is 0, `cpu_tx_valid`/`cpu_tx_data` appear on `tx_valid`/`tx_data` in the same cycle.
- R3: Opcode 0x01 (store) with count N writes N words. The payload is 4N bytes, each word least significant byte first. Word k goes to address A+4k, with one single-cycle `mem_we` pulse per word. Only then is the byte 0xAC sent.
- R4: A frame is dropped when the sync is wrong, the opcode is outside 0x01..0x04, or the checksum does not match. A dropped frame causes no memory strobe and no debug transmit byte, and leaves `tx_owner_dbg` unchanged.
- R5: An accepted frame sets `tx_owner_dbg` to 1 before any reply byte. While it is 1, processor transmit bytes never reach `tx_valid`.
- R6: Opcode 0x02 (fetch) with count N returns N words from addresses A+4k, least significant byte first, and then 0xAC. It carries no payload. Memory read data is valid the cycle after `mem_re`.
- R7: Opcode 0x03 (run) sends 0xAC and then loads A into `cpu_start_pc`. `cpu_hold` falls exactly one cycle after `cpu_start_pc` changes, together with `tx_owner_dbg` returning to 0.
- R8: Opcode 0x04 (halt) raises `cpu_hold` and sends 0xAC.
- R9: Store and fetch frames that arrive while the processor runs are dropped. `mem_we` and `mem_re` are never active while `cpu_hold` is 0.
- R10: TIMEOUT_CYC consecutive cycles without a byte in the middle of a frame return the parser to sync search. A shorter gap does not break the frame.
- R11: A store or fetch frame whose count exceeds MAX_WORDS is dropped.
- R12: Bytes that arrive while a command is being carried out are not parsed. They are still delivered to the processor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Incoming byte strobe |
| rx_data | input | 8 | Incoming byte |
| cpu_rx_valid | output | 1 | Byte strobe to processor receiver |
| cpu_rx_data | output | 8 | Byte to processor receiver |
| cpu_tx_valid | input | 1 | Processor transmit strobe |
| cpu_tx_data | input | 8 | Processor transmit byte |
| tx_valid | output | 1 | Outgoing byte strobe on the shared line |
| tx_data | output | 8 | Outgoing byte on the shared line |
| tx_owner_dbg | output | 1 | Selector state, 1 = debug side drives the line |
| cpu_hold | output | 1 | Processor stall request |
| cpu_start_pc | output | 32 | Start address for the processor |
| mem_we | output | 1 | Word write strobe |
| mem_re | output | 1 | Word read strobe |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after `mem_re` |

## Verification
Two activities can meet on one cycle: the processor presenting a transmit byte, and the debug side sending a reply byte. The bench holds `cpu_tx_valid` high for the whole length of an accepted store frame. The run passes only if the single acknowledge byte shows up on the line. A second collision is a new frame sent while a long fetch is still streaming out. That frame must leave memory and the reply stream untouched, and its bytes must still reach the processor receiver.

// File: rtl/dbg_loader_pkg.sv
package dbg_loader_pkg;
  localparam logic [7:0] SYNC_HI  = 8'h5A;
  localparam logic [7:0] SYNC_LO  = 8'hA5;
  localparam logic [7:0] ACK_CODE = 8'hAC;
  localparam logic [7:0] OP_STORE = 8'h01;
  localparam logic [7:0] OP_FETCH = 8'h02;
  localparam logic [7:0] OP_RUN   = 8'h03;
  localparam logic [7:0] OP_HALT  = 8'h04;

  typedef enum logic [2:0] {
    PS_SYNC0, PS_SYNC1, PS_CMD, PS_ADDR, PS_LEN, PS_PAY, PS_CHK
  } pstate_e;

  typedef enum logic [3:0] {
    XS_IDLE, XS_WFETCH, XS_WSTORE, XS_RREQ, XS_RWAIT, XS_RCAP,
    XS_RSEND, XS_ACK, XS_REL, XS_REL2
  } xstate_e;

  typedef struct packed {
    logic [7:0]  op;
    logic [31:0] addr;
    logic [7:0]  len;
  } cmd_t;
endpackage

// File: rtl/dbg_word_buf.sv
module dbg_word_buf #(
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [31:0]   wdata,
  input  logic [AW-1:0] raddr,
  output logic [31:0]   rdata
);
  logic [31:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    rdata <= store[raddr];
  end
endmodule

// File: rtl/dbg_frame_parser.sv
module dbg_frame_parser
  import dbg_loader_pkg::*;
#(
  parameter int MAX_WORDS   = 16,
  parameter int TIMEOUT_CYC = 65535,
  parameter int BUF_AW      = 4,
  parameter int IDX_W       = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              block_i,
  input  logic              held_i,
  output logic              buf_we,
  output logic [BUF_AW-1:0] buf_waddr,
  output logic [31:0]       buf_wdata,
  output logic              cmd_valid,
  output cmd_t              cmd
);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);

  pstate_e          state;
  logic [7:0]       chk;
  logic [1:0]       bcnt;
  logic [IDX_W-1:0] widx;
  logic [31:0]      wsr;
  logic [TW-1:0]    idle;
  logic             take;
  logic             mem_op;

  assign take   = rx_valid && !block_i && !cmd_valid;
  assign mem_op = (cmd.op == OP_STORE) || (cmd.op == OP_FETCH);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= PS_SYNC0;
      cmd_valid <= 1'b0;
      buf_we    <= 1'b0;
      buf_waddr <= '0;
      buf_wdata <= '0;
      cmd       <= '0;
      chk       <= '0;
      bcnt      <= '0;
      widx      <= '0;
      wsr       <= '0;
      idle      <= '0;
    end else begin
      cmd_valid <= 1'b0;
      buf_we    <= 1'b0;
      if (take || state == PS_SYNC0) idle <= '0;
      else idle <= idle + 1'b1;

      if (!take && state != PS_SYNC0 && idle == TW'(TIMEOUT_CYC - 1)) begin
        state <= PS_SYNC0;
      end else if (take) begin
        case (state)
          PS_SYNC0: if (rx_data == SYNC_HI) state <= PS_SYNC1;
          PS_SYNC1: begin
            if (rx_data == SYNC_LO) state <= PS_CMD;
            else if (rx_data != SYNC_HI) state <= PS_SYNC0;
          end
          PS_CMD: begin
            cmd.op <= rx_data;
            chk    <= rx_data;
            bcnt   <= '0;
            if ((((rx_data == OP_STORE) || (rx_data == OP_FETCH)) && held_i) ||
                (rx_data == OP_RUN) || (rx_data == OP_HALT))
              state <= PS_ADDR;
            else
              state <= PS_SYNC0;
          end
          PS_ADDR: begin
            cmd.addr <= {rx_data, cmd.addr[31:8]};
            chk      <= chk ^ rx_data;
            bcnt     <= bcnt + 1'b1;
            if (bcnt == 2'd3) state <= PS_LEN;
          end
          PS_LEN: begin
            cmd.len <= rx_data;
            chk     <= chk ^ rx_data;
            widx    <= '0;
            bcnt    <= '0;
            if (mem_op && rx_data > 8'(MAX_WORDS)) state <= PS_SYNC0;
            else if (cmd.op == OP_STORE && rx_data != 8'd0) state <= PS_PAY;
            else state <= PS_CHK;
          end
          PS_PAY: begin
            wsr  <= {rx_data, wsr[31:8]};
            chk  <= chk ^ rx_data;
            bcnt <= bcnt + 1'b1;
            if (bcnt == 2'd3) begin
              buf_we    <= 1'b1;
              buf_waddr <= widx[BUF_AW-1:0];
              buf_wdata <= {rx_data, wsr[31:8]};
              widx      <= widx + 1'b1;
              if (8'(widx) + 8'd1 == cmd.len) state <= PS_CHK;
            end
          end
          PS_CHK: begin
            if (rx_data == chk) cmd_valid <= 1'b1;
            state <= PS_SYNC0;
          end
          default: state <= PS_SYNC0;
        endcase
      end
    end
  end
endmodule

// File: rtl/dbg_exec.sv
module dbg_exec
  import dbg_loader_pkg::*;
#(
  parameter int          BUF_AW   = 4,
  parameter int          IDX_W    = 5,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  cmd_t              cmd,
  output logic              busy,
  output logic [BUF_AW-1:0] buf_raddr,
  input  logic [31:0]       buf_rdata,
  output logic              mem_we,
  output logic              mem_re,
  output logic [31:0]       mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  output logic              dbg_tx_valid,
  output logic [7:0]        dbg_tx_data,
  output logic              tx_owner_dbg,
  output logic              cpu_hold,
  output logic [31:0]       cpu_start_pc
);
  xstate_e          st;
  cmd_t             cur;
  logic [IDX_W-1:0] idx;
  logic [1:0]       bsel;
  logic [31:0]      shreg;
  logic             last_word;
  logic [31:0]      word_addr;

  assign busy      = (st != XS_IDLE);
  assign buf_raddr = idx[BUF_AW-1:0];
  assign last_word = (8'(idx) + 8'd1 == cur.len);
  assign word_addr = cur.addr + (32'(idx) << 2);

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= XS_IDLE;
      cur          <= '0;
      idx          <= '0;
      bsel         <= '0;
      shreg        <= '0;
      mem_we       <= 1'b0;
      mem_re       <= 1'b0;
      mem_addr     <= '0;
      mem_wdata    <= '0;
      dbg_tx_valid <= 1'b0;
      dbg_tx_data  <= '0;
      tx_owner_dbg <= 1'b0;
      cpu_hold     <= 1'b1;
      cpu_start_pc <= RESET_PC;
    end else begin
      mem_we       <= 1'b0;
      mem_re       <= 1'b0;
      dbg_tx_valid <= 1'b0;
      case (st)
        XS_IDLE: if (cmd_valid) begin
          cur          <= cmd;
          idx          <= '0;
          tx_owner_dbg <= 1'b1;
          if (cmd.op == OP_STORE)      st <= (cmd.len == 8'd0) ? XS_ACK : XS_WFETCH;
          else if (cmd.op == OP_FETCH) st <= (cmd.len == 8'd0) ? XS_ACK : XS_RREQ;
          else begin
            if (cmd.op == OP_HALT) cpu_hold <= 1'b1;
            st <= XS_ACK;
          end
        end
        XS_WFETCH: st <= XS_WSTORE;
        XS_WSTORE: begin
          mem_we    <= 1'b1;
          mem_addr  <= word_addr;
          mem_wdata <= buf_rdata;
          idx       <= idx + 1'b1;
          st        <= last_word ? XS_ACK : XS_WFETCH;
        end
        XS_RREQ: begin
          mem_re   <= 1'b1;
          mem_addr <= word_addr;
          st       <= XS_RWAIT;
        end
        XS_RWAIT: st <= XS_RCAP;
        XS_RCAP: begin
          shreg <= mem_rdata;
          bsel  <= '0;
          st    <= XS_RSEND;
        end
        XS_RSEND: begin
          dbg_tx_valid <= 1'b1;
          dbg_tx_data  <= shreg[7:0];
          shreg        <= {8'h00, shreg[31:8]};
          bsel         <= bsel + 1'b1;
          if (bsel == 2'd3) begin
            idx <= idx + 1'b1;
            st  <= last_word ? XS_ACK : XS_RREQ;
          end
        end
        XS_ACK: begin
          dbg_tx_valid <= 1'b1;
          dbg_tx_data  <= ACK_CODE;
          st           <= (cur.op == OP_RUN) ? XS_REL : XS_IDLE;
        end
        XS_REL: begin
          cpu_start_pc <= cur.addr;
          st           <= XS_REL2;
        end
        XS_REL2: begin
          cpu_hold     <= 1'b0;
          tx_owner_dbg <= 1'b0;
          st           <= XS_IDLE;
        end
        default: st <= XS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dbg_loader_ctrl.sv
module dbg_loader_ctrl
  import dbg_loader_pkg::*;
#(
  parameter int          MAX_WORDS   = 16,
  parameter int          TIMEOUT_CYC = 65535,
  parameter logic [31:0] RESET_PC    = 32'h0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  output logic        cpu_rx_valid,
  output logic [7:0]  cpu_rx_data,
  input  logic        cpu_tx_valid,
  input  logic [7:0]  cpu_tx_data,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  output logic        tx_owner_dbg,
  output logic        cpu_hold,
  output logic [31:0] cpu_start_pc,
  output logic        mem_we,
  output logic        mem_re,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata
);
  localparam int BUF_AW = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1;
  localparam int IDX_W  = BUF_AW + 1;

  logic              busy;
  logic              buf_we;
  logic [BUF_AW-1:0] buf_waddr;
  logic [BUF_AW-1:0] buf_raddr;
  logic [31:0]       buf_wdata;
  logic [31:0]       buf_rdata;
  logic              cmd_valid;
  cmd_t              cmd;
  logic              dbg_tx_valid;
  logic [7:0]        dbg_tx_data;

  assign cpu_rx_valid = rx_valid;
  assign cpu_rx_data  = rx_data;
  assign tx_valid     = tx_owner_dbg ? dbg_tx_valid : cpu_tx_valid;
  assign tx_data      = tx_owner_dbg ? dbg_tx_data  : cpu_tx_data;

  dbg_frame_parser #(
    .MAX_WORDS(MAX_WORDS), .TIMEOUT_CYC(TIMEOUT_CYC), .BUF_AW(BUF_AW), .IDX_W(IDX_W)
  ) u_parser (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
    .block_i(busy), .held_i(cpu_hold),
    .buf_we(buf_we), .buf_waddr(buf_waddr), .buf_wdata(buf_wdata),
    .cmd_valid(cmd_valid), .cmd(cmd)
  );

  dbg_word_buf #(.DEPTH(MAX_WORDS), .AW(BUF_AW)) u_buf (
    .clk(clk), .we(buf_we), .waddr(buf_waddr), .wdata(buf_wdata),
    .raddr(buf_raddr), .rdata(buf_rdata)
  );

  dbg_exec #(.BUF_AW(BUF_AW), .IDX_W(IDX_W), .RESET_PC(RESET_PC)) u_exec (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd(cmd), .busy(busy),
    .buf_raddr(buf_raddr), .buf_rdata(buf_rdata),
    .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .dbg_tx_valid(dbg_tx_valid), .dbg_tx_data(dbg_tx_data),
    .tx_owner_dbg(tx_owner_dbg), .cpu_hold(cpu_hold), .cpu_start_pc(cpu_start_pc)
  );
endmodule

// File: rtl/dbg_loader_ctrl_chk.sv
module dbg_loader_ctrl_chk (
  input logic        clk,
  input logic        rst,
  input logic        cpu_hold,
  input logic        tx_owner_dbg,
  input logic [31:0] cpu_start_pc,
  input logic        mem_we,
  input logic        mem_re,
  input logic        dbg_tx_valid
);
  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cpu_hold && !tx_owner_dbg && !mem_we && !mem_re)); // R1

  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we); // R3

  AST_DBG_TX_OWNED: assert property (@(posedge clk) disable iff (rst)
    dbg_tx_valid |-> tx_owner_dbg); // R5

  AST_RELEASE_ORDER: assert property (@(posedge clk) disable iff (rst)
    $fell(cpu_hold) |-> (!tx_owner_dbg && $past(tx_owner_dbg) && $stable(cpu_start_pc))); // R7

  AST_MEM_IDLE_RUN: assert property (@(posedge clk) disable iff (rst)
    !cpu_hold |-> !(mem_we || mem_re)); // R9
endmodule

bind dbg_loader_ctrl dbg_loader_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .cpu_hold(cpu_hold), .tx_owner_dbg(tx_owner_dbg),
  .cpu_start_pc(cpu_start_pc), .mem_we(mem_we), .mem_re(mem_re),
  .dbg_tx_valid(dbg_tx_valid)
);

// File: tb/dbg_loader_ctrl_tb_top.sv
module dbg_loader_ctrl_tb_top;
  localparam int MAXW = 4;
  localparam int TMO  = 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = 8'h00;
  logic        cpu_rx_valid;
  logic [7:0]  cpu_rx_data;
  logic        cpu_tx_valid = 1'b0;
  logic [7:0]  cpu_tx_data = 8'h00;
  logic        tx_valid;
  logic [7:0]  tx_data;
  logic        tx_owner_dbg;
  logic        cpu_hold;
  logic [31:0] cpu_start_pc;
  logic        mem_we;
  logic        mem_re;
  logic [31:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = 32'h0;

  dbg_loader_ctrl #(.MAX_WORDS(MAXW), .TIMEOUT_CYC(TMO), .RESET_PC(32'h0)) dut_i (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
    .cpu_rx_valid(cpu_rx_valid), .cpu_rx_data(cpu_rx_data),
    .cpu_tx_valid(cpu_tx_valid), .cpu_tx_data(cpu_tx_data),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_owner_dbg(tx_owner_dbg),
    .cpu_hold(cpu_hold), .cpu_start_pc(cpu_start_pc),
    .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // memory model: write on strobe, read data one cycle after strobe
  logic [31:0] model [0:255];
  always @(posedge clk) begin
    if (mem_we) model[mem_addr[9:2]] <= mem_wdata;
    if (mem_re) mem_rdata <= model[mem_addr[9:2]];
  end

  // line monitor, samples 15 ns after the rising edge
  int         tx_cnt = 0;
  int         we_cnt = 0;
  logic [7:0] txlog [0:63];
  always begin
    @(posedge clk);
    #15;
    if (tx_valid) begin
      if (tx_cnt < 64) txlog[tx_cnt] = tx_data;
      tx_cnt++;
    end
    if (mem_we) we_cnt++;
  end

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic report_end();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  function automatic logic [31:0] word_of(input logic [7:0] s, input int k);
    logic [7:0] kb;
    kb = 8'(k);
    return {s, kb, ~s, kb ^ 8'h3c};
  endfunction

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_data  = b;
  endtask

  // bad: 0 good, 1 checksum corrupted, 2 sync corrupted; gap: idle cycles after opcode
  task automatic send_frame(input logic [7:0] op, input logic [31:0] a, input logic [7:0] n,
                            input logic [7:0] seed, input int bad, input int gap);
    logic [7:0]  c;
    logic [31:0] w;
    c = op;
    send_byte(bad == 2 ? 8'h5B : 8'h5A);
    send_byte(8'hA5);
    send_byte(op);
    if (gap > 0) begin
      @(negedge clk);
      rx_valid = 1'b0;
      repeat (gap - 1) @(negedge clk);
    end
    for (int i = 0; i < 4; i++) begin
      send_byte(a[8*i +: 8]);
      c = c ^ a[8*i +: 8];
    end
    send_byte(n);
    c = c ^ n;
    if (op == 8'h01) begin
      for (int k = 0; k < int'(n); k++) begin
        w = word_of(seed, k);
        for (int j = 0; j < 4; j++) begin
          send_byte(w[8*j +: 8]);
          c = c ^ w[8*j +: 8];
        end
      end
    end
    send_byte(bad == 1 ? ~c : c);
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic clear_logs();
    @(negedge clk);
    tx_cnt = 0;
    we_cnt = 0;
  endtask

  task automatic settle();
    repeat (80) @(negedge clk);
  endtask

  task automatic check_fetch(input string req, input logic [31:0] a, input int n);
    logic [31:0] w;
    chk_eq({req, " byte count"}, 32'(tx_cnt), 32'(4 * n + 1));
    for (int k = 0; k < n; k++) begin
      w = model[(int'(a[9:2]) + k) & 255];
      for (int j = 0; j < 4; j++)
        chk_eq({req, " data byte"}, 32'(txlog[4*k + j]), 32'(w[8*j +: 8]));
    end
    chk_eq({req, " ack last"}, 32'(txlog[4*n]), 32'hAC);
  endtask

  task automatic check_store(input string req, input logic [31:0] a, input int n,
                             input logic [7:0] seed);
    chk_eq({req, " ack count"}, 32'(tx_cnt), 32'd1);
    chk_eq({req, " ack byte"}, 32'(txlog[0]), 32'hAC);
    chk_eq({req, " strobes"}, 32'(we_cnt), 32'(n));
    for (int k = 0; k < n; k++)
      chk_eq({req, " word"}, model[(int'(a[9:2]) + k) & 255], word_of(seed, k));
  endtask

  task automatic check_dropped(input string req, input logic [31:0] a, input logic [31:0] old);
    chk_eq({req, " no tx"}, 32'(tx_cnt), 32'd0);
    chk_eq({req, " no strobe"}, 32'(we_cnt), 32'd0);
    chk_eq({req, " mem kept"}, model[a[9:2]], old);
  endtask

  // {op, addr, count, seed, bad}
  localparam int NV = 10;
  localparam logic [59:0] VEC [NV] = '{
    {8'h01, 32'h0000_0040, 8'd2, 8'h11, 4'd0},
    {8'h02, 32'h0000_0040, 8'd2, 8'h00, 4'd0},
    {8'h01, 32'h0000_0080, 8'd4, 8'h22, 4'd0},
    {8'h01, 32'h0000_0080, 8'd1, 8'h33, 4'd1},
    {8'h01, 32'h0000_0090, 8'd1, 8'h44, 4'd2},
    {8'h02, 32'h0000_0080, 8'd4, 8'h00, 4'd0},
    {8'h07, 32'h0000_0010, 8'd0, 8'h00, 4'd0},
    {8'h01, 32'h0000_00A0, 8'd0, 8'h00, 4'd0},
    {8'h02, 32'h0000_0084, 8'd1, 8'h00, 4'd0},
    {8'h01, 32'h0000_0040, 8'd1, 8'h55, 4'd0}
  };

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report_end();
  end

  initial begin
    logic [31:0] old;
    logic [7:0]  op, n, seed;
    logic [31:0] a;
    int          bad;
    bit          acc;
    logic        h_arr [0:39];
    logic        s_arr [0:39];
    logic [31:0] p_arr [0:39];
    int          p_i, h_i;

    for (int i = 0; i < 256; i++) model[i] = 32'hC0DE_0000 | 32'(i);
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk_eq("R1 hold after reset", 32'(cpu_hold), 32'd1);
    chk_eq("R1 selector after reset", 32'(tx_owner_dbg), 32'd0);
    chk_eq("R1 start pc after reset", cpu_start_pc, 32'h0);
    chk_eq("R1 no strobe after reset", 32'({mem_we, mem_re}), 32'd0);

    // R2: pass-through in both directions
    rx_valid = 1'b1; rx_data = 8'h3C; cpu_tx_valid = 1'b1; cpu_tx_data = 8'h77;
    #1;
    chk_eq("R2 rx to cpu", 32'({cpu_rx_valid, cpu_rx_data}), 32'h13C);
    chk_eq("R2 cpu tx on line", 32'({tx_valid, tx_data}), 32'h177);
    @(negedge clk);
    rx_valid = 1'b0; cpu_tx_valid = 1'b0;

    // R4: bad checksum leaves selector with the processor
    old = model[8'h04];
    clear_logs();
    send_frame(8'h01, 32'h10, 8'd1, 8'h13, 1, 0);
    settle();
    check_dropped("R4 bad checksum before first accept", 32'h10, old);
    chk_eq("R4 selector unchanged", 32'(tx_owner_dbg), 32'd0);

    // table walk: R3, R4, R6
    for (int v = 0; v < NV; v++) begin
      op = VEC[v][59:52]; a = VEC[v][51:20]; n = VEC[v][19:12];
      seed = VEC[v][11:4]; bad = int'(VEC[v][3:0]);
      acc = (bad == 0) && (op >= 8'h01) && (op <= 8'h04);
      old = model[a[9:2]];
      clear_logs();
      send_frame(op, a, n, seed, bad, 0);
      settle();
      if (!acc) check_dropped("R4 malformed frame", a, old);
      else if (op == 8'h01) check_store("R3 store", a, int'(n), seed);
      else check_fetch("R6 fetch", a, int'(n));
    end
    chk_eq("R5 selector taken after accept", 32'(tx_owner_dbg), 32'd1);

    // R5: processor transmitting throughout an accepted frame
    @(negedge clk);
    cpu_tx_valid = 1'b1; cpu_tx_data = 8'h99;
    clear_logs();
    send_frame(8'h01, 32'h50, 8'd1, 8'h66, 0, 0);
    settle();
    cpu_tx_valid = 1'b0;
    check_store("R5 only debug bytes on line", 32'h50, 1, 8'h66);

    // R12: frame arriving during a long fetch is ignored
    old = model[8'h18];
    clear_logs();
    send_frame(8'h02, 32'h40, 8'(MAXW), 8'h00, 0, 0);
    send_frame(8'h01, 32'h60, 8'd1, 8'h77, 0, 0);
    settle();
    check_fetch("R12 fetch stream intact", 32'h40, MAXW);
    chk_eq("R12 no strobe from ignored frame", 32'(we_cnt), 32'd0);
    chk_eq("R12 mem kept", model[8'h18], old);

    // R10: idle timeout mid-frame
    old = model[8'h1C];
    clear_logs();
    send_frame(8'h01, 32'h70, 8'd1, 8'h12, 0, TMO + 2);
    settle();
    check_dropped("R10 long gap drops frame", 32'h70, old);
    clear_logs();
    send_frame(8'h01, 32'h70, 8'd1, 8'h12, 0, 0);
    settle();
    check_store("R10 parser back in sync search", 32'h70, 1, 8'h12);
    clear_logs();
    send_frame(8'h01, 32'h74, 8'd1, 8'h14, 0, TMO - 4);
    settle();
    check_store("R10 short gap keeps frame", 32'h74, 1, 8'h14);

    // R11: count beyond capacity
    old = model[8'h20];
    clear_logs();
    send_frame(8'h01, 32'h80, 8'(MAXW + 1), 8'h21, 0, 0);
    settle();
    check_dropped("R11 oversize store", 32'h80, old);
    clear_logs();
    send_frame(8'h02, 32'h80, 8'(MAXW + 1), 8'h00, 0, 0);
    settle();
    chk_eq("R11 oversize fetch no tx", 32'(tx_cnt), 32'd0);

    // R7: release
    clear_logs();
    send_frame(8'h03, 32'h100, 8'd0, 8'h00, 0, 0);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      h_arr[i] = cpu_hold; s_arr[i] = tx_owner_dbg; p_arr[i] = cpu_start_pc;
    end
    p_i = -1; h_i = -1;
    for (int i = 39; i >= 0; i--) begin
      if (p_arr[i] == 32'h100) p_i = i;
      if (!h_arr[i]) h_i = i;
    end
    chk_eq("R7 ack on release", 32'({tx_cnt[7:0], txlog[0]}), 32'h01AC);
    chk_eq("R7 pc loaded", 32'(p_i >= 0), 32'd1);
    chk_eq("R7 hold falls one cycle after pc", 32'(h_i), 32'(p_i + 1));
    if (p_i >= 0 && p_i < 39) begin
      chk_eq("R7 held while pc loads", 32'(h_arr[p_i]), 32'd1);
      chk_eq("R7 selector returned", 32'(s_arr[p_i + 1]), 32'd0);
    end

    // R9: memory commands while running
    old = model[8'h10];
    clear_logs();
    send_frame(8'h01, 32'h40, 8'd1, 8'h31, 0, 0);
    settle();
    check_dropped("R9 store while running", 32'h40, old);
    clear_logs();
    send_frame(8'h02, 32'h40, 8'd1, 8'h00, 0, 0);
    settle();
    chk_eq("R9 fetch while running no tx", 32'(tx_cnt), 32'd0);
    chk_eq("R9 still running", 32'(cpu_hold), 32'd0);

    // R8: halt
    clear_logs();
    send_frame(8'h04, 32'h0, 8'd0, 8'h00, 0, 0);
    settle();
    chk_eq("R8 hold raised", 32'(cpu_hold), 32'd1);
    chk_eq("R8 selector debug", 32'(tx_owner_dbg), 32'd1);
    chk_eq("R8 ack", 32'({tx_cnt[7:0], txlog[0]}), 32'h01AC);
    clear_logs();
    send_frame(8'h01, 32'h44, 8'd1, 8'h19, 0, 0);
    settle();
    check_store("R8 store accepted after halt", 32'h44, 1, 8'h19);

    report_end();
  end
endmodule